// File: doc/BRIEF.md
# Interleaved modular multiplier

This block computes the modular product (A·B) mod m for two n-bit operands that are both smaller than a modulus m supplied at run time. It does not divide. It scans the bits of B one per clock, starting at the most significant bit. In each cycle it doubles the running value, adds A when the current bit of B is set, and folds the sum back into the range [0, m).

The unreduced sum in any cycle is always below 3m. Two subtractors therefore compute the sum minus m and the sum minus 2m in parallel, and a three-way select driven by their two sign bits picks the one candidate that lies in range. A run costs n cycles after the start pulse is accepted. The caller then sees a one-cycle done pulse, and the result stays stable until the next run starts.

The controller has two states. IDLE waits for start. RUN performs one iteration per cycle. Its transitions are:
- ACCEPT: IDLE to RUN on start. The operands are captured and the running value is cleared.
- STEP: RUN to RUN while bits remain.
- FINISH: RUN to IDLE after the last bit is consumed. This transition raises done.

Top module: `modmul_interleave`

## Requirements
- R1: While reset is held and in the first cycle after it, done is 0 and result is 0.
- R2: For every 2 ≤ m < 2^n and every A, B < m, the result reported with done equals (A·B) mod m. This includes m = 3 and the largest n-bit modulus.
- R3: Bits of B are consumed most significant bit first, starting from a running value of 0. The running value stays below m throughout RUN. For example, with A = 15 and m = 23, the values of B 1, 3, 6 and 13 (the prefixes of binary 1101) give 15, 22, 21 and 11.
- R4: done is high in the cycle that follows exactly n clock edges after the edge that accepts start.
- R5: done is high for exactly one cycle per run.
- R6: result holds its value from done until the next accepted start.
- R7: A start pulse, together with any operand values, presented while a run is in RUN is ignored. The run finishes with its original operands and its original timing.
- R8: A start presented in the cycle where done is high is accepted and begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run; sampled only in IDLE |
| op_a | input | WIDTH | Multiplicand A, less than modulus |
| op_b | input | WIDTH | Multiplier B, less than modulus, scanned MSB first |
| modulus | input | WIDTH | Modulus m, at least 2 |
| done | output | 1 | One-cycle pulse when result is valid |
| result | output | WIDTH | (A·B) mod m, held until the next start |

## Verification
The result and done of a run are due after n rising edges following the edge that samples start. The bench counts edges from that accepting edge, reads done and result at the falling edge after each count, and requires done to appear exactly at count n. It then confirms that done is low one falling edge later, and that result is still unchanged several cycles after that. Every operand triple of a 5-bit configuration is swept. Mid-run start pulses and back-to-back starts are judged against the same edge count.

// File: rtl/modmul_pkg.sv
package modmul_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mm_state_t;
endpackage

// File: rtl/mm_reduce.sv
// Folds an unreduced sum u < 3m into [0, m) by picking among u, u-m, u-2m.
module mm_reduce #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH+1:0] sum_in,
    input  logic [WIDTH-1:0] mod_in,
    output logic [WIDTH-1:0] red_out
);
    localparam int SW = WIDTH + 3;

    logic [SW-1:0] sum_x;
    logic [SW-1:0] neg_m;
    logic [SW-1:0] neg_2m;
    logic [SW-1:0] diff_1;
    logic [SW-1:0] diff_2;

    always_comb begin
        sum_x  = {1'b0, sum_in};
        neg_m  = ~{3'b000, mod_in} + SW'(1);
        neg_2m = ~{2'b00, mod_in, 1'b0} + SW'(1);
        diff_1 = sum_x + neg_m;
        diff_2 = sum_x + neg_2m;
    end

    always_comb begin
        unique case ({diff_2[SW-1], diff_1[SW-1]})
            2'b00:   red_out = diff_2[WIDTH-1:0];
            2'b10:   red_out = diff_1[WIDTH-1:0];
            default: red_out = sum_x[WIDTH-1:0];
        endcase
    end
endmodule

// File: rtl/mm_ctrl.sv
// Iteration controller: IDLE / RUN with a down-counting bit index.
module mm_ctrl
    import modmul_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int IDXW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    output logic            load,
    output logic            step,
    output logic [IDXW-1:0] bit_idx,
    output logic            done
);
    mm_state_t       state_q, state_d;
    logic [IDXW-1:0] idx_q, idx_d;
    logic            done_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            done    <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            done    <= done_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        done_d  = 1'b0;
        load    = 1'b0;
        step    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin            // ACCEPT
                    load    = 1'b1;
                    idx_d   = IDXW'(WIDTH - 1);
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                step = 1'b1;
                if (idx_q == '0) begin      // FINISH
                    done_d  = 1'b1;
                    state_d = ST_IDLE;
                end else begin              // STEP
                    idx_d = idx_q - IDXW'(1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign bit_idx = idx_q;

    // R5: done is a single-cycle pulse
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: a start seen together with done opens a new run
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> (state_q == ST_RUN));
endmodule

// File: rtl/modmul_interleave.sv
// Sequential modular multiplier: P <- (2P + b_i*A) mod m, MSB first.
module modmul_interleave #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [WIDTH-1:0] modulus,
    output logic             done,
    output logic [WIDTH-1:0] result
);
    localparam int IDXW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam int CNTW = $clog2(WIDTH + 1) + 1;

    logic [WIDTH-1:0] a_q, b_q, m_q, acc_q;
    logic [WIDTH-1:0] addend, acc_next;
    logic [WIDTH+1:0] raw_sum;
    logic [IDXW-1:0]  bit_idx;
    logic             load, step;

    mm_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .load   (load),
        .step   (step),
        .bit_idx(bit_idx),
        .done   (done)
    );

    // n AND gates form b_i * A; doubling is a wire shift
    always_comb begin
        addend  = a_q & {WIDTH{b_q[bit_idx]}};
        raw_sum = {1'b0, acc_q, 1'b0} + {2'b00, addend};
    end

    mm_reduce #(.WIDTH(WIDTH)) u_reduce (
        .sum_in (raw_sum),
        .mod_in (m_q),
        .red_out(acc_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q   <= '0;
            b_q   <= '0;
            m_q   <= '0;
            acc_q <= '0;
        end else if (load) begin
            a_q   <= op_a;
            b_q   <= op_b;
            m_q   <= modulus;
            acc_q <= '0;
        end else if (step) begin
            acc_q <= acc_next;
        end
    end

    assign result = acc_q;

    // checker counter: cycles spent in RUN since the accepting edge
    logic [CNTW-1:0] run_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     run_len <= '0;
        else if (load)  run_len <= '0;
        else if (step)  run_len <= run_len + CNTW'(1);
    end

    // R3: running value stays inside [0, m) during iteration
    p_acc_below_mod_r3: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (acc_q < m_q));
    // R4: done arrives after exactly WIDTH iterations
    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_len == CNTW'(WIDTH)));
    // R6: result is held while idle and no start arrives
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !start) |=> $stable(result));
    // R7: captured operands do not move during a run
    p_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !done) |=> ($stable(m_q) && $stable(a_q) && $stable(b_q)));
endmodule

// File: tb/test_modmul_interleave.sv
module test_modmul_interleave;
    localparam int W = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] op_a = '0, op_b = '0, modulus = '0;
    logic         done;
    logic [W-1:0] result;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    modmul_interleave #(.WIDTH(W)) i_modmul_interleave (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .modulus(modulus), .done(done), .result(result)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drives one run; optional mid-run start with junk operands at iteration 'poke'.
    task automatic run(input int a, input int b, input int m, input int poke,
                       output int res, output int lat);
        int k;
        @(negedge clk);
        op_a = W'(a); op_b = W'(b); modulus = W'(m); start = 1'b1;
        @(posedge clk);               // accepting edge
        k = 0;
        lat = -1;
        while (k < 4 * W) begin
            @(posedge clk);
            k++;
            @(negedge clk);
            start = 1'b0;
            if (k == poke) begin
                start = 1'b1; op_a = W'(m - 1); op_b = W'(m - 1);
                modulus = W'(31);
            end
            if (done) begin lat = k; break; end
        end
        res = int'(result);
        start = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int res, lat;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1 done in reset", int'(done), 0);
        check(result == '0, "R1 result in reset", int'(result), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0 && result == '0, "R1 after reset", int'(result), 0);

        // R3: MSB-first prefixes of B = 1101 with A = 15, m = 23
        run(15, 1, 23, 0, res, lat);  check(res == 15, "R3 prefix 1", res, 15);
        run(15, 3, 23, 0, res, lat);  check(res == 22, "R3 prefix 11", res, 22);
        run(15, 6, 23, 0, res, lat);  check(res == 21, "R3 prefix 110", res, 21);
        run(15, 13, 23, 0, res, lat); check(res == 11, "R3 prefix 1101", res, 11);
        check(lat == W, "R4 latency example", lat, W);

        // R5 and R6: one-cycle done, result held afterwards
        @(negedge clk);
        check(done == 1'b0, "R5 done drops", int'(done), 0);
        repeat (4) @(negedge clk);
        check(int'(result) == 11, "R6 result held", int'(result), 11);

        // R7: start during RUN ignored (operands would give a different answer)
        run(7, 9, 23, 2, res, lat);
        check(res == (7 * 9) % 23, "R7 busy start ignored", res, (7 * 9) % 23);
        check(lat == W, "R7 timing unchanged", lat, W);
        @(negedge clk);
        check(done == 1'b0, "R7 no second done", int'(done), 0);

        // R8: start asserted in the done cycle begins a new run
        run(30, 29, 31, 0, res, lat);
        check(res == (30 * 29) % 31, "R8 first run", res, (30 * 29) % 31);
        op_a = W'(2); op_b = W'(2); modulus = W'(3); start = 1'b1;  // done still high
        @(posedge clk);
        begin
            int k = 0;
            lat = -1;
            while (k < 4 * W) begin
                @(posedge clk); k++;
                @(negedge clk); start = 1'b0;
                if (done) begin lat = k; break; end
            end
        end
        check(lat == W, "R8 back-to-back latency", lat, W);
        check(int'(result) == 1, "R8 back-to-back result", int'(result), 1);

        // R2 and R4: exhaustive sweep, m = 2..31 (includes 3 and 31)
        for (int m = 2; m < (1 << W); m++) begin
            for (int a = 0; a < m; a++) begin
                for (int b = 0; b < m; b++) begin
                    run(a, b, m, 0, res, lat);
                    check(res == (a * b) % m, "R2 sweep", res, (a * b) % m);
                    check(lat == W, "R4 sweep latency", lat, W);
                end
            end
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule